// File: doc/BRIEF.md
# Scaled Address Execute Unit

This unit decodes and executes two scaled-index address instructions for a 64-bit register machine. In both instructions, one source operand (the index) is shifted left by a small amount, and the other source operand (the base) is added to it. The shift is taken from a 2-bit instruction field plus one. The word form keeps a 32-bit sum and sign-extends it to 64 bits. The doubleword form keeps the full 64-bit sum.

Each cycle, the surrounding pipeline presents an instruction word with a valid strobe, the two operand values read from the register file, and a flag saying whether 64-bit instructions are enabled. One clock later, the unit returns one of three outcomes:

- a result with a destination index and a write request;
- a reserved-instruction exception;
- a flag saying the word was not one of its two instructions.

Register storage, fetch, hazards and exception dispatch stay outside the unit.

Top module: `sxa_exec_unit`

## Requirements
- R1: The instruction word is split from the most significant bit down as major opcode [31:26], base register index [25:21], index register index [20:16], destination index [15:11], scale field [10:9], subfield [8:6] and minor opcode [5:0]. The word form is recognised when the major opcode is 6'b000000, the subfield is 3'b000 and the minor opcode is 6'b001111.
- R2: The doubleword form is recognised when the major opcode is 6'b010110, the subfield is 3'b100 and the minor opcode is 6'b000100. With 64-bit mode enabled, it requests a register write.
- R3: The index operand `src_idx` is shifted left by the unsigned scale field plus one, which gives shifts of 1, 2, 3 or 4.
- R4: The word form keeps bits 31:0 of (src_idx << shift) + src_base and copies bit 31 into bits 63:32. The upper 32 bits of both operands have no effect on the result.
- R5: The doubleword form computes (src_idx << shift) + src_base at 64 bits. Bits shifted above bit 63 and the carry out of bit 63 are dropped.
- R6: The doubleword form with `mode64_en` low raises `out_rsvd_exc` and leaves `out_wen` low.
- R7: The word form never raises `out_rsvd_exc`, whatever the value of `mode64_en`.
- R8: The outputs appear on the clock edge after a valid input and last for that one cycle only. When `in_valid` is low, the next cycle shows `out_wen`, `out_rsvd_exc` and `out_nomatch` all low.
- R9: A valid word that matches neither encoding raises `out_nomatch` with `out_wen` and `out_rsvd_exc` low. At most one of the three flags is high in any cycle.
- R10: A synchronous active-high reset clears `out_wen`, `out_rsvd_exc` and `out_nomatch`.
- R11: `out_dest` carries the destination field [15:11] of the accepted instruction. A destination of 0 is still reported with `out_wen` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_idx | input | 64 | Operand that is shifted (scaled index) |
| src_base | input | 64 | Operand that is added unshifted (base) |
| mode64_en | input | 1 | 64-bit instructions are enabled |
| out_result | output | 64 | Registered result |
| out_dest | output | 5 | Registered destination register index |
| out_wen | output | 1 | Register write request, one cycle |
| out_rsvd_exc | output | 1 | Reserved-instruction exception, one cycle |
| out_nomatch | output | 1 | Valid word was not a scaled-address instruction, one cycle |

## Verification
The hardest case to reach from the ports is a word-form sum whose bit 31 differs from what the operands' own upper halves would suggest. This happens when a carry into bit 31, or an index bit pushed into bit 31 by the shift, must become the sign while junk in bits 63:32 of both operands is discarded. The stimulus builds such operands on purpose for every scale value. It also sends near-miss encodings that differ from a valid form in only the subfield or the minor opcode. On top of that, a long biased random run draws mostly valid encodings with extreme operand values, and toggles the valid strobe and the 64-bit enable between back-to-back instructions.

// File: rtl/sxa_pkg.sv
package sxa_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned REG_IDX_W = 5;

   // field positions inside the instruction word (decoded by neighbours too)
   localparam int unsigned MAJ_HI = 31;
   localparam int unsigned MAJ_LO = 26;
   localparam int unsigned RB_HI  = 25;
   localparam int unsigned RB_LO  = 21;
   localparam int unsigned RI_HI  = 20;
   localparam int unsigned RI_LO  = 16;
   localparam int unsigned RD_HI  = 15;
   localparam int unsigned RD_LO  = 11;
   localparam int unsigned SC_HI  = 10;
   localparam int unsigned SC_LO  = 9;
   localparam int unsigned SUB_HI = 8;
   localparam int unsigned SUB_LO = 6;
   localparam int unsigned MIN_HI = 5;
   localparam int unsigned MIN_LO = 0;

   localparam int unsigned SCALE_W = SC_HI - SC_LO + 1;

   // encodings
   localparam logic [5:0] WORD_MAJ  = 6'b000000;
   localparam logic [2:0] WORD_SUB  = 3'b000;
   localparam logic [5:0] WORD_MIN  = 6'b001111;
   localparam logic [5:0] DWORD_MAJ = 6'b010110;
   localparam logic [2:0] DWORD_SUB = 3'b100;
   localparam logic [5:0] DWORD_MIN = 6'b000100;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WORD  = 2'd1,
      OP_DWORD = 2'd2
   } sxa_op_e;

   typedef struct packed {
      sxa_op_e                op;
      logic [REG_IDX_W-1:0]   dest;
      logic [SCALE_W-1:0]     scale;
   } sxa_dec_t;

   typedef enum logic [1:0] {
      OUT_IDLE  = 2'd0,
      OUT_WRITE = 2'd1,
      OUT_EXC   = 2'd2,
      OUT_MISS  = 2'd3
   } sxa_outcome_e;

endpackage

// File: rtl/sxa_decode.sv
module sxa_decode
   import sxa_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output sxa_dec_t           dec
);

   logic [5:0] maj;
   logic [2:0] sub;
   logic [5:0] mnr;
   logic       hit_word;
   logic       hit_dword;
   logic       unused_src_fields;

   assign maj = instr[MAJ_HI:MAJ_LO];
   assign sub = instr[SUB_HI:SUB_LO];
   assign mnr = instr[MIN_HI:MIN_LO];

   // register indices of the sources are consumed by the register file read
   assign unused_src_fields = ^{instr[RB_HI:RB_LO], instr[RI_HI:RI_LO]};

   assign hit_word  = (maj == WORD_MAJ)  && (sub == WORD_SUB)  && (mnr == WORD_MIN);
   assign hit_dword = (maj == DWORD_MAJ) && (sub == DWORD_SUB) && (mnr == DWORD_MIN);

   always_comb begin
      dec.dest  = instr[RD_HI:RD_LO];
      dec.scale = instr[SC_HI:SC_LO];
      if (hit_word) begin
         dec.op = OP_WORD;
      end else if (hit_dword) begin
         dec.op = OP_DWORD;
      end else begin
         dec.op = OP_NONE;
      end
   end

endmodule

// File: rtl/sxa_scale_add.sv
module sxa_scale_add #(
   parameter int unsigned W       = 64,
   parameter int unsigned SCALE_W = 2
) (
   input  logic [W-1:0]       idx,
   input  logic [W-1:0]       base,
   input  logic [SCALE_W-1:0] scale,
   output logic [W-1:0]       sum
);

   localparam int unsigned NSHIFT = 1 << SCALE_W;

   if (W <= NSHIFT) begin : g_bad_width
      $error("sxa_scale_add: W must exceed the largest shift");
   end

   logic [W-1:0] cand [NSHIFT];
   logic [W-1:0] shifted;

   // one fixed-shift wire per scale value; the selector picks one
   for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
      assign cand[g] = {idx[W-2-g:0], {(g + 1){1'b0}}};
   end

   assign shifted = cand[scale];
   assign sum     = shifted + base;

endmodule

// File: rtl/sxa_out_reg.sv
module sxa_out_reg
   import sxa_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                 clk,
   input  logic                 rst,
   input  sxa_outcome_e         outcome,
   input  logic [XLEN-1:0]      result_d,
   input  logic [REG_IDX_W-1:0] dest_d,
   output logic [XLEN-1:0]      result_q,
   output logic [REG_IDX_W-1:0] dest_q,
   output logic                 wen_q,
   output logic                 exc_q,
   output logic                 miss_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         wen_q  <= 1'b0;
         exc_q  <= 1'b0;
         miss_q <= 1'b0;
      end else begin
         wen_q  <= (outcome == OUT_WRITE);
         exc_q  <= (outcome == OUT_EXC);
         miss_q <= (outcome == OUT_MISS);
      end
   end

   // data path loads only on a write, so it holds otherwise
   always_ff @(posedge clk) begin
      if (rst) begin
         result_q <= '0;
         dest_q   <= '0;
      end else if (outcome == OUT_WRITE) begin
         result_q <= result_d;
         dest_q   <= dest_d;
      end
   end

endmodule

// File: rtl/sxa_exec_unit.sv
module sxa_exec_unit
   import sxa_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned WLEN         = 32,
   parameter bit          SHARE_ADDER  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [31:0]          instr,
   input  logic [XLEN-1:0]      src_idx,
   input  logic [XLEN-1:0]      src_base,
   input  logic                 mode64_en,
   output logic [XLEN-1:0]      out_result,
   output logic [4:0]           out_dest,
   output logic                 out_wen,
   output logic                 out_rsvd_exc,
   output logic                 out_nomatch
);

   localparam int unsigned EXT_W = XLEN - WLEN;

   if (WLEN >= XLEN) begin : g_bad_len
      $error("sxa_exec_unit: WLEN must be narrower than XLEN");
   end
   if (REG_IDX_W != 5 || INSTR_W != 32) begin : g_bad_pkg
      $error("sxa_exec_unit: package widths do not match the port list");
   end

   sxa_dec_t     dec;
   logic [XLEN-1:0] full_sum;
   logic [WLEN-1:0] word_sum;
   logic [XLEN-1:0] word_ext;
   logic [XLEN-1:0] result_d;
   sxa_outcome_e outcome;

   sxa_decode u_decode (
      .instr (instr),
      .dec   (dec)
   );

   sxa_scale_add #(
      .W       (XLEN),
      .SCALE_W (SCALE_W)
   ) u_add_full (
      .idx   (src_idx),
      .base  (src_base),
      .scale (dec.scale),
      .sum   (full_sum)
   );

   if (SHARE_ADDER) begin : g_shared
      // low bits of a sum depend only on low bits of the operands
      assign word_sum = full_sum[WLEN-1:0];
   end else begin : g_split
      sxa_scale_add #(
         .W       (WLEN),
         .SCALE_W (SCALE_W)
      ) u_add_word (
         .idx   (src_idx[WLEN-1:0]),
         .base  (src_base[WLEN-1:0]),
         .scale (dec.scale),
         .sum   (word_sum)
      );
   end

   assign word_ext = {{EXT_W{word_sum[WLEN-1]}}, word_sum};
   assign result_d = (dec.op == OP_WORD) ? word_ext : full_sum;

   always_comb begin
      if (!in_valid) begin
         outcome = OUT_IDLE;
      end else begin
         unique case (dec.op)
            OP_WORD:  outcome = OUT_WRITE;
            OP_DWORD: outcome = mode64_en ? OUT_WRITE : OUT_EXC;
            default:  outcome = OUT_MISS;
         endcase
      end
   end

   sxa_out_reg #(
      .XLEN (XLEN)
   ) u_out (
      .clk      (clk),
      .rst      (rst),
      .outcome  (outcome),
      .result_d (result_d),
      .dest_d   (dec.dest),
      .result_q (out_result),
      .dest_q   (out_dest),
      .wen_q    (out_wen),
      .exc_q    (out_rsvd_exc),
      .miss_q   (out_nomatch)
   );

endmodule

// File: rtl/sxa_exec_chk.sv
module sxa_exec_chk #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned WLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic [31:0]     instr,
   input logic            mode64_en,
   input logic [XLEN-1:0] out_result,
   input logic [4:0]      out_dest,
   input logic            out_wen,
   input logic            out_rsvd_exc,
   input logic            out_nomatch
);

   logic is_w;
   logic is_d;
   assign is_w = (instr[31:26] == 6'b000000) && (instr[8:6] == 3'b000) && (instr[5:0] == 6'b001111);
   assign is_d = (instr[31:26] == 6'b010110) && (instr[8:6] == 3'b100) && (instr[5:0] == 6'b000100);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_wen && !out_rsvd_exc && !out_nomatch));

   a_r9_flags_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0({out_wen, out_rsvd_exc, out_nomatch}));

   a_r9_miss_flag: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !is_w && !is_d) |=> out_nomatch);

   a_r6_exc_when_off: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_d && !mode64_en) |=> (out_rsvd_exc && !out_wen));

   a_r7_word_no_exc: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_w) |=> (!out_rsvd_exc && out_wen));

   a_r4_sign_ext: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_w) |=> (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));

   a_r11_dest: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (is_w || (is_d && mode64_en))) |=> (out_dest == $past(instr[15:11])));

   a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (!out_wen && !out_rsvd_exc && !out_nomatch));

endmodule

bind sxa_exec_unit sxa_exec_chk #(
   .XLEN (XLEN),
   .WLEN (WLEN)
) i_sxa_exec_chk (
   .clk          (clk),
   .rst          (rst),
   .in_valid     (in_valid),
   .instr        (instr),
   .mode64_en    (mode64_en),
   .out_result   (out_result),
   .out_dest     (out_dest),
   .out_wen      (out_wen),
   .out_rsvd_exc (out_rsvd_exc),
   .out_nomatch  (out_nomatch)
);

// File: tb/test_sxa_exec_unit.sv
module test_sxa_exec_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] src_idx = '0;
   logic [63:0] src_base = '0;
   logic        mode64_en = 1'b0;
   logic [63:0] out_result;
   logic [4:0]  out_dest;
   logic        out_wen;
   logic        out_rsvd_exc;
   logic        out_nomatch;

   int total = 0;
   int bad = 0;

   // expectation for the outputs after the next clock edge
   logic        have_exp = 1'b0;
   logic        e_wen, e_exc, e_miss;
   logic [63:0] e_res;
   logic [4:0]  e_dest;
   string       e_tag;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sxa_exec_unit i_sxa_exec_unit (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .instr        (instr),
      .src_idx      (src_idx),
      .src_base     (src_base),
      .mode64_en    (mode64_en),
      .out_result   (out_result),
      .out_dest     (out_dest),
      .out_wen      (out_wen),
      .out_rsvd_exc (out_rsvd_exc),
      .out_nomatch  (out_nomatch)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [5:0] maj, logic [4:0] rd, logic [1:0] sc,
                                      logic [2:0] sub, logic [5:0] mnr);
      return {maj, 5'd7, 5'd9, rd, sc, sub, mnr};
   endfunction

   function automatic logic [31:0] mk_w(logic [4:0] rd, logic [1:0] sc);
      return mk(6'b000000, rd, sc, 3'b000, 6'b001111);
   endfunction

   function automatic logic [31:0] mk_d(logic [4:0] rd, logic [1:0] sc);
      return mk(6'b010110, rd, sc, 3'b100, 6'b000100);
   endfunction

   // reference: multiply by the scale factor instead of shifting
   task automatic model(logic v, logic [31:0] iw, logic [63:0] a, logic [63:0] b, logic m64);
      logic        w, d;
      logic [63:0] s;
      int          k;
      w = (iw[31:26] == 6'd0) && (iw[8:6] == 3'd0) && (iw[5:0] == 6'd15);
      d = (iw[31:26] == 6'd22) && (iw[8:6] == 3'd4) && (iw[5:0] == 6'd4);
      k = int'(iw[10:9]) + 1;
      s = a * (64'd1 << k) + b;
      e_wen  = v && (w || (d && m64));
      e_exc  = v && d && !m64;
      e_miss = v && !w && !d;
      e_dest = iw[15:11];
      e_res  = w ? {{32{s[31]}}, s[31:0]} : s;
      if (!v)              e_tag = "R8";
      else if (w)          e_tag = "R1 R3 R4 R7";
      else if (d && m64)   e_tag = "R2 R3 R5";
      else if (d)          e_tag = "R6";
      else                 e_tag = "R9";
   endtask

   task automatic compare();
      string t;
      t = rst ? "R10" : e_tag;
      chk({t, " wen"},  64'(out_wen),      64'(e_wen));
      chk({t, " exc"},  64'(out_rsvd_exc), 64'(e_exc));
      chk({t, " miss"}, 64'(out_nomatch),  64'(e_miss));
      if (e_wen) begin
         chk({t, " R11 dest"}, 64'(out_dest), 64'(e_dest));
         chk({t, " result"},   out_result,    e_res);
      end
   endtask

   // one cycle: check the previous edge's outcome, then apply new inputs
   task automatic step(logic v, logic [31:0] iw, logic [63:0] a, logic [63:0] b, logic m64);
      @(negedge clk);
      if (have_exp) compare();
      in_valid  = v;
      instr     = iw;
      src_idx   = a;
      src_base  = b;
      mode64_en = m64;
      if (rst) begin
         e_wen = 1'b0; e_exc = 1'b0; e_miss = 1'b0; e_tag = "R10";
      end else begin
         model(v, iw, a, b, m64);
      end
      have_exp = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // reset with a valid word present: flags must stay clear (R10)
      rst = 1'b1;
      step(1'b1, mk_w(5'd3, 2'd0), 64'd5, 64'd1, 1'b1);
      step(1'b1, mk_d(5'd3, 2'd0), 64'd5, 64'd1, 1'b0);
      step(1'b1, 32'hffff_ffff, 64'd5, 64'd1, 1'b1);
      @(negedge clk);
      rst = 1'b0;
      have_exp = 1'b0;
      step(1'b0, 32'h0, 64'd0, 64'd0, 1'b0);

      // word form, every scale, carry into bit 31, junk in upper halves (R3 R4)
      for (int sc = 0; sc < 4; sc++) begin
         step(1'b1, mk_w(5'(sc + 1), 2'(sc)), 64'hdead_beef_0000_0001, 64'h1234_5678_0000_0003, 1'b1);
         step(1'b1, mk_w(5'(sc + 5), 2'(sc)), 64'hffff_0000_1000_0000 >> sc, 64'haaaa_aaaa_7fff_ffff, 1'b0);
         step(1'b1, mk_w(5'(sc + 9), 2'(sc)), 64'h0000_0001_4000_0000, 64'h0000_0000_0000_0000, 1'b1);
      end
      // word form with negative base wrapping back to positive (R4)
      step(1'b1, mk_w(5'd2, 2'd1), 64'd1, 64'hffff_ffff_ffff_fffc, 1'b0);
      // doubleword form, every scale, overflow dropped (R5)
      for (int sc = 0; sc < 4; sc++) begin
         step(1'b1, mk_d(5'(sc + 16), 2'(sc)), 64'hf000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1);
         step(1'b1, mk_d(5'(sc + 20), 2'(sc)), 64'h0000_0001_8000_0000, 64'h0000_0000_ffff_ffff, 1'b1);
      end
      // doubleword with 64-bit mode off (R6), then word with mode off (R7)
      step(1'b1, mk_d(5'd4, 2'd2), 64'd3, 64'd4, 1'b0);
      step(1'b1, mk_w(5'd4, 2'd2), 64'd3, 64'd4, 1'b0);
      // near misses (R9)
      step(1'b1, mk(6'b000000, 5'd1, 2'd0, 3'b100, 6'b001111), 64'd1, 64'd1, 1'b1);
      step(1'b1, mk(6'b000000, 5'd1, 2'd0, 3'b000, 6'b001110), 64'd1, 64'd1, 1'b1);
      step(1'b1, mk(6'b010110, 5'd1, 2'd0, 3'b000, 6'b000100), 64'd1, 64'd1, 1'b0);
      step(1'b1, mk(6'b010111, 5'd1, 2'd0, 3'b100, 6'b000100), 64'd1, 64'd1, 1'b1);
      // a matching word with valid low produces nothing (R8)
      step(1'b0, mk_w(5'd6, 2'd3), 64'd1, 64'd1, 1'b1);
      step(1'b0, mk_d(5'd6, 2'd3), 64'd1, 64'd1, 1'b0);
      // destination zero still writes (R11)
      step(1'b1, mk_w(5'd0, 2'd3), 64'h0000_0000_0800_0000, 64'd7, 1'b1);
      step(1'b1, mk_d(5'd0, 2'd3), 64'h1000_0000_0000_0000, 64'd7, 1'b1);
      step(1'b0, 32'h0, 64'd0, 64'd0, 1'b0);

      // biased random run
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] iw;
         logic [63:0] a, b;
         int          pick;
         pick = int'($urandom_range(0, 9));
         if (pick < 4)      iw = mk_w(5'($urandom), 2'($urandom));
         else if (pick < 8) iw = mk_d(5'($urandom), 2'($urandom));
         else               iw = $urandom;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) a = 64'hffff_ffff_ffff_ffff;
         if ($urandom_range(0, 3) == 0) b = 64'h8000_0000_7fff_ffff;
         step($urandom_range(0, 4) != 0, iw, a, b, 1'($urandom));
      end

      // mid-run reset clears pending outcome (R10)
      step(1'b1, mk_d(5'd9, 2'd1), 64'd2, 64'd2, 1'b0);
      @(negedge clk);
      compare();
      rst = 1'b1;
      in_valid = 1'b1;
      instr = mk_w(5'd9, 2'd1);
      @(negedge clk);
      chk("R10 wen",  64'(out_wen), 64'd0);
      chk("R10 miss", 64'(out_nomatch), 64'd0);
      chk("R10 exc",  64'(out_rsvd_exc), 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule